// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write side of a parallel NOR flash command port. It turns a stream of synchronous write strobes into decoded flash operations. Each strobe carries a word address, a byte-lane select bit, a data word and a flag that tells whether the bus is in 8-bit or 16-bit mode. The decoder checks the two-cycle unlock prefix, whose key addresses depend on the bus width. It tracks which read view the array port should present: the array, the identifier view or the parameter-query view. It also tracks the unlock-bypass and erase-suspend states.

Decoded operations come out as a one-cycle `cmd_valid` pulse with an encoded identifier, plus the address and data of the write that completed the command. An external program/erase engine consumes these pulses and reports back through `busy`. The array, the timing engines and all voltage-level paths live outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `cmd_valid` is 0, `read_mode` is 0 (array), and `bypass_on` and `suspended` are 0. A reset in mid-operation returns to this state.
- R2: Unlock keys are compared on a 12-bit key address. In word mode (`byte_mode`=0) the key address is `{0, wr_addr[10:0]}`, the first key write is data AA at 555 and the second is data 55 at 2AA. In byte mode the key address is `{wr_addr[10:0], wr_lsb}`, and the two keys are AA at AAA and 55 at 555.
- R3: Unlock prefix, then A0, then one more write gives a single-cycle `cmd_valid` with `cmd_id`=1 (program). The pulse appears in the cycle after the edge that samples that last write, and it carries that write's address, lane bit and data. Every emitted command carries the address and data of the write that triggered it.
- R4: Prefix, then 80, then a second prefix, then a sixth write. If the sixth write is 10 at the first key address, the result is `cmd_id`=2 (chip erase). If it is 30 at any address, the result is `cmd_id`=3 (block erase), carrying that address.
- R5: Prefix followed by 90 sets `read_mode`=1 (identifier view). A single write of F0 to any address, or the prefix followed by F0, leaves that view.
- R6: Data 98 at key address 055 (word mode) or 0AA (byte mode) sets `read_mode`=2 (query view), but only from `read_mode` 0 or 1. A reset write (F0) returns to the mode held before entry, so leaving a query view entered from the identifier view takes two F0 writes.
- R7: Only key-address bits (address bits 10:0, plus the lane bit in byte mode) and data bits 7:0 are compared. Higher address and data bits have no effect.
- R8: A write that breaks a sequence in progress, or a write in idle that matches no command, sets `read_mode` to 0 and emits nothing.
- R9: Prefix followed by 20 sets `bypass_on`=1. In bypass, A0 to any address and then one write gives a program command. Data 90 followed by 00 clears `bypass_on`. Other writes in bypass are ignored.
- R10: While `busy`=1 and `suspended`=0, every write except data B0 is ignored: no mode change and no command. Data B0 then emits `cmd_id`=4 (suspend) and sets `suspended`=1.
- R11: While suspended, the identifier view can be entered. F0 from it returns `read_mode` to 0 and leaves `suspended` at 1. A single write of 30 emits `cmd_id`=5 (resume), clears `suspended` and sets `read_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_lsb | input | 1 | Byte-lane select, used as the lowest key-address bit in byte mode |
| wr_data | input | DATA_W | Write data; only bits 7:0 are decoded |
| byte_mode | input | 1 | 1 = 8-bit bus keys, 0 = 16-bit bus keys |
| busy | input | 1 | Program/erase engine is running |
| cmd_valid | output | 1 | One-cycle decoded-command pulse |
| cmd_id | output | 3 | 1 program, 2 chip erase, 3 block erase, 4 suspend, 5 resume |
| cmd_addr | output | ADDR_W | Address of the triggering write |
| cmd_lsb | output | 1 | Lane bit of the triggering write |
| cmd_data | output | DATA_W | Data of the triggering write |
| read_mode | output | 2 | 0 array, 1 identifier, 2 query |
| bypass_on | output | 1 | Unlock-bypass state active |
| suspended | output | 1 | Erase-suspend state active |

## Verification
The bench drives word-mode keys while `byte_mode`=1. A decoder that ignored the width flag would enter the identifier view there, instead of falling back to the array. It nests the query view inside the identifier view and needs two resets to get out. A decoder with a single-level return would land in the array after the first reset. It sends unlock writes and F0 while busy and unsuspended. A design without gating would enter the identifier view or leave it. In suspend, F0 must not clear the suspend flag, and a six-cycle erase broken at the fifth write must emit nothing, even when a matching sixth write follows.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int KEY_W = 12;

    typedef enum logic [2:0] {
        CMD_NONE        = 3'd0,
        CMD_PROGRAM     = 3'd1,
        CMD_CHIP_ERASE  = 3'd2,
        CMD_BLOCK_ERASE = 3'd3,
        CMD_SUSPEND     = 3'd4,
        CMD_RESUME      = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        RM_ARRAY   = 2'd0,
        RM_AUTOSEL = 2'd1,
        RM_CFI     = 2'd2
    } rmode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_U1, S_U2, S_PROG,
        S_E1, S_E2, S_E3,
        S_BYP, S_BYP_PROG, S_BYP_EXIT
    } seq_e;

    typedef struct packed {
        logic to_array;
        logic to_autosel;
        logic cfi_enter;
        logic reset_pop;
        logic suspend;
        logic resume;
    } mode_ev_t;

    typedef struct packed {
        logic u1;
        logic u2;
        logic cfi;
    } key_hit_t;

    localparam logic [7:0] D_KEY1     = 8'hAA;
    localparam logic [7:0] D_KEY2     = 8'h55;
    localparam logic [7:0] D_IDENT    = 8'h90;
    localparam logic [7:0] D_PROG     = 8'hA0;
    localparam logic [7:0] D_BYPASS   = 8'h20;
    localparam logic [7:0] D_ERASE    = 8'h80;
    localparam logic [7:0] D_CHIP     = 8'h10;
    localparam logic [7:0] D_BLOCK    = 8'h30;
    localparam logic [7:0] D_RESET    = 8'hF0;
    localparam logic [7:0] D_QUERY    = 8'h98;
    localparam logic [7:0] D_SUSP     = 8'hB0;
    localparam logic [7:0] D_RESUME   = 8'h30;
    localparam logic [7:0] D_BYP_EXIT = 8'h00;

    // key addresses, index 0 = first key, 1 = second key, 2 = query entry
    localparam logic [KEY_W-1:0] WORD_KEYS [3] = '{12'h555, 12'h2AA, 12'h055};
    localparam logic [KEY_W-1:0] BYTE_KEYS [3] = '{12'hAAA, 12'h555, 12'h0AA};

    function automatic logic [KEY_W-1:0] key_addr(input logic [10:0] a,
                                                  input logic lsb,
                                                  input logic bmode);
        return bmode ? {a, lsb} : {1'b0, a};
    endfunction

endpackage

// File: rtl/fcd_addr_keys.sv
module fcd_addr_keys
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic              byte_mode,
    output key_hit_t          hit
);
    localparam int NKEYS = 3;

    logic [KEY_W-1:0] kaddr;
    logic [NKEYS-1:0] m;

    assign kaddr = key_addr(wr_addr[10:0], wr_lsb, byte_mode);

    for (genvar i = 0; i < NKEYS; i++) begin : g_key
        assign m[i] = (kaddr == (byte_mode ? BYTE_KEYS[i] : WORD_KEYS[i]));
    end

    assign hit = '{u1: m[0], u2: m[1], cfi: m[2]};
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  key_hit_t          hit,
    input  rmode_e            cur_mode,
    input  logic              susp,
    output mode_ev_t          ev,
    output logic              cmd_valid,
    output cmd_e              cmd_id,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_lsb,
    output logic [DATA_W-1:0] cmd_data,
    output logic              in_bypass
);
    seq_e       st, nxt;
    logic       fire;
    cmd_e       fid;
    logic [7:0] d;
    logic       hold;

    assign d    = wr_data[7:0];
    assign hold = busy && !susp;

    always_comb begin
        nxt  = st;
        ev   = '0;
        fire = 1'b0;
        fid  = CMD_NONE;
        if (wr_en) begin
            if (hold) begin
                if (d == D_SUSP) begin
                    ev.suspend = 1'b1;
                    fire       = 1'b1;
                    fid        = CMD_SUSPEND;
                end
            end else begin
                case (st)
                    S_IDLE: begin
                        if (d == D_RESET)
                            ev.reset_pop = 1'b1;
                        else if (d == D_QUERY && hit.cfi && cur_mode != RM_CFI)
                            ev.cfi_enter = 1'b1;
                        else if (d == D_RESUME && susp) begin
                            ev.resume = 1'b1;
                            fire      = 1'b1;
                            fid       = CMD_RESUME;
                        end else if (d == D_KEY1 && hit.u1)
                            nxt = S_U1;
                        else
                            ev.to_array = 1'b1;
                    end
                    S_U1: begin
                        if (d == D_KEY2 && hit.u2)
                            nxt = S_U2;
                        else begin
                            nxt         = S_IDLE;
                            ev.to_array = 1'b1;
                        end
                    end
                    S_U2: begin
                        nxt = S_IDLE;
                        case (d)
                            D_IDENT:  ev.to_autosel = 1'b1;
                            D_PROG:   nxt = S_PROG;
                            D_BYPASS: begin
                                ev.to_array = 1'b1;
                                if (!susp) nxt = S_BYP;
                            end
                            D_ERASE: begin
                                if (!susp) nxt = S_E1;
                                else ev.to_array = 1'b1;
                            end
                            D_RESET:  ev.reset_pop = 1'b1;
                            default:  ev.to_array = 1'b1;
                        endcase
                    end
                    S_PROG: begin
                        nxt  = S_IDLE;
                        fire = 1'b1;
                        fid  = CMD_PROGRAM;
                    end
                    S_E1: begin
                        if (d == D_KEY1 && hit.u1)
                            nxt = S_E2;
                        else begin
                            nxt         = S_IDLE;
                            ev.to_array = 1'b1;
                        end
                    end
                    S_E2: begin
                        if (d == D_KEY2 && hit.u2)
                            nxt = S_E3;
                        else begin
                            nxt         = S_IDLE;
                            ev.to_array = 1'b1;
                        end
                    end
                    S_E3: begin
                        nxt = S_IDLE;
                        if (d == D_CHIP && hit.u1) begin
                            fire = 1'b1;
                            fid  = CMD_CHIP_ERASE;
                        end else if (d == D_BLOCK) begin
                            fire = 1'b1;
                            fid  = CMD_BLOCK_ERASE;
                        end else
                            ev.to_array = 1'b1;
                    end
                    S_BYP: begin
                        if (d == D_PROG)       nxt = S_BYP_PROG;
                        else if (d == D_IDENT) nxt = S_BYP_EXIT;
                    end
                    S_BYP_PROG: begin
                        nxt  = S_BYP;
                        fire = 1'b1;
                        fid  = CMD_PROGRAM;
                    end
                    S_BYP_EXIT: begin
                        nxt = (d == D_BYP_EXIT) ? S_IDLE : S_BYP;
                    end
                    default: nxt = S_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cmd_valid <= 1'b0;
            cmd_id    <= CMD_NONE;
            cmd_addr  <= '0;
            cmd_lsb   <= 1'b0;
            cmd_data  <= '0;
        end else begin
            st        <= nxt;
            cmd_valid <= fire;
            cmd_id    <= fire ? fid : CMD_NONE;
            if (fire) begin
                cmd_addr <= wr_addr;
                cmd_lsb  <= wr_lsb;
                cmd_data <= wr_data;
            end
        end
    end

    assign in_bypass = (st == S_BYP) || (st == S_BYP_PROG) || (st == S_BYP_EXIT);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    a_r10_hold_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !susp && wr_data[7:0] != D_SUSP) |=> ($stable(st) && !cmd_valid));

    a_r10_suspend_when_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_id == CMD_SUSPEND) |-> $past(busy));

    a_r11_resume_when_susp: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_id == CMD_RESUME) |-> $past(susp));

    a_r3_cmd_needs_write: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(wr_en));
endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
    import flash_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mode_ev_t ev,
    output rmode_e   read_mode,
    output logic     susp
);
    rmode_e cfi_ret;

    always_ff @(posedge clk) begin
        if (rst) begin
            read_mode <= RM_ARRAY;
            cfi_ret   <= RM_ARRAY;
            susp      <= 1'b0;
        end else begin
            if (ev.reset_pop)
                read_mode <= (read_mode == RM_CFI) ? cfi_ret : RM_ARRAY;
            else if (ev.cfi_enter) begin
                cfi_ret   <= read_mode;
                read_mode <= RM_CFI;
            end else if (ev.to_autosel)
                read_mode <= RM_AUTOSEL;
            else if (ev.to_array || ev.resume)
                read_mode <= RM_ARRAY;

            if (ev.suspend)     susp <= 1'b1;
            else if (ev.resume) susp <= 1'b0;
        end
    end

    a_r6_cfi_entry_event: assert property (@(posedge clk) disable iff (rst)
        (read_mode == RM_CFI && $past(read_mode) != RM_CFI) |-> $past(ev.cfi_enter));

    a_r8_quiet_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (ev == '0) |=> ($stable(read_mode) && $stable(susp)));

    a_r11_resume_clears: assert property (@(posedge clk) disable iff (rst)
        ev.resume |=> (!susp && read_mode == RM_ARRAY));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_id,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_lsb,
    output logic [DATA_W-1:0] cmd_data,
    output logic [1:0]        read_mode,
    output logic              bypass_on,
    output logic              suspended
);
    key_hit_t hit;
    mode_ev_t ev;
    rmode_e   mode_q;
    cmd_e     cmd_q;
    logic     susp_q;

    fcd_addr_keys #(.ADDR_W(ADDR_W)) u_keys (
        .wr_addr   (wr_addr),
        .wr_lsb    (wr_lsb),
        .byte_mode (byte_mode),
        .hit       (hit)
    );

    fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_lsb    (wr_lsb),
        .wr_data   (wr_data),
        .busy      (busy),
        .hit       (hit),
        .cur_mode  (mode_q),
        .susp      (susp_q),
        .ev        (ev),
        .cmd_valid (cmd_valid),
        .cmd_id    (cmd_q),
        .cmd_addr  (cmd_addr),
        .cmd_lsb   (cmd_lsb),
        .cmd_data  (cmd_data),
        .in_bypass (bypass_on)
    );

    fcd_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .read_mode (mode_q),
        .susp      (susp_q)
    );

    assign cmd_id    = cmd_q;
    assign read_mode = mode_q;
    assign suspended = susp_q;
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic        wr_lsb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        byte_mode = 1'b0;
    logic        busy = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_id;
    logic [19:0] cmd_addr;
    logic        cmd_lsb;
    logic [15:0] cmd_data;
    logic [1:0]  read_mode;
    logic        bypass_on;
    logic        suspended;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    flash_cmd_decoder uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lsb(wr_lsb),
        .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_addr(cmd_addr), .cmd_lsb(cmd_lsb),
        .cmd_data(cmd_data), .read_mode(read_mode), .bypass_on(bypass_on),
        .suspended(suspended)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one write at a falling edge, return at the next falling edge
    task automatic wr(input logic [19:0] a, input logic l, input logic [15:0] d);
        wr_addr = a; wr_lsb = l; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    typedef struct packed {
        logic [19:0] a;
        logic        l;
        logic [15:0] d;
        logic        bm;
        logic        bz;
        logic        ev;
        logic [2:0]  ec;
        logic [1:0]  em;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 63;
    localparam vec_t VECS [NV] = '{
        // R3 program in word mode
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd3},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd3},
        '{20'h00555, 1'b0, 16'h00A0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd3},
        '{20'h12345, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b1, 3'd1, 2'd0, 4'd3},
        // R5 identifier view and single F0 exit
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd5},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd5},
        '{20'h00555, 1'b0, 16'h0090, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 4'd5},
        '{20'h00000, 1'b0, 16'h00F0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd5},
        // R6 query nested in identifier view: two F0 to leave
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd6},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd6},
        '{20'h00555, 1'b0, 16'h0090, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 4'd6},
        '{20'h00055, 1'b0, 16'h0098, 1'b0, 1'b0, 1'b0, 3'd0, 2'd2, 4'd6},
        '{20'h00123, 1'b0, 16'h00F0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 4'd6},
        '{20'h00123, 1'b0, 16'h00F0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd6},
        // R2 byte-mode keys, then word keys in byte mode break (R8)
        '{20'h00555, 1'b0, 16'h00AA, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 4'd2},
        '{20'h002AA, 1'b1, 16'h0055, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 4'd2},
        '{20'h00555, 1'b0, 16'h0090, 1'b1, 1'b0, 1'b0, 3'd0, 2'd1, 4'd2},
        '{20'h00555, 1'b1, 16'h00AA, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 4'd2},
        // R7 upper address and data bits ignored
        '{20'hFF555, 1'b0, 16'hFFAA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd7},
        '{20'h7A2AA, 1'b0, 16'h1255, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd7},
        '{20'hC4555, 1'b0, 16'h3390, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 4'd7},
        '{20'h00000, 1'b0, 16'hABF0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd7},
        // R4 chip erase
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h00555, 1'b0, 16'h0080, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h00555, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b1, 3'd2, 2'd0, 4'd4},
        // R4 block erase at any address
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h00555, 1'b0, 16'h0080, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd4},
        '{20'h40000, 1'b0, 16'h0030, 1'b0, 1'b0, 1'b1, 3'd3, 2'd0, 4'd4},
        // R8 erase broken at fifth write, sixth write emits nothing
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd8},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd8},
        '{20'h00555, 1'b0, 16'h0080, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd8},
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd8},
        '{20'h002AA, 1'b0, 16'h0077, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd8},
        '{20'h00555, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd8},
        // R9 bypass program, exit, then A0 alone does nothing
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        '{20'h00555, 1'b0, 16'h0020, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        '{20'h00000, 1'b0, 16'h00A0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        '{20'h00100, 1'b0, 16'h5A5A, 1'b0, 1'b0, 1'b1, 3'd1, 2'd0, 4'd9},
        '{20'h00000, 1'b0, 16'h0090, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        '{20'h00000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        '{20'h00000, 1'b0, 16'h00A0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        '{20'h00000, 1'b0, 16'h1111, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd9},
        // R10 busy gating and suspend, R11 identifier view during suspend
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd10},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd10},
        '{20'h00555, 1'b0, 16'h0090, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 4'd10},
        '{20'h00000, 1'b0, 16'h00F0, 1'b0, 1'b1, 1'b0, 3'd0, 2'd1, 4'd10},
        '{20'h00003, 1'b0, 16'h00B0, 1'b0, 1'b1, 1'b1, 3'd4, 2'd1, 4'd10},
        '{20'h00000, 1'b0, 16'h00F0, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 4'd11},
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 4'd11},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 4'd11},
        '{20'h00555, 1'b0, 16'h0090, 1'b0, 1'b1, 1'b0, 3'd0, 2'd1, 4'd11},
        '{20'h00000, 1'b0, 16'h00F0, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 4'd11},
        '{20'h00044, 1'b0, 16'h0030, 1'b0, 1'b1, 1'b1, 3'd5, 2'd0, 4'd11},
        '{20'h00555, 1'b0, 16'h00AA, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 4'd10},
        '{20'h002AA, 1'b0, 16'h0055, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 4'd10},
        '{20'h00555, 1'b0, 16'h0090, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 4'd10}
    };

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "cmd_valid", 32'(cmd_valid), 32'd0);
        chk("R1", "read_mode", 32'(read_mode), 32'd0);
        chk("R1", "bypass_on", 32'(bypass_on), 32'd0);
        chk("R1", "suspended", 32'(suspended), 32'd0);

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            byte_mode = VECS[i].bm;
            busy      = VECS[i].bz;
            wr(VECS[i].a, VECS[i].l, VECS[i].d);
            chk(tag, "cmd_valid", 32'(cmd_valid), 32'(VECS[i].ev));
            chk(tag, "read_mode", 32'(read_mode), 32'(VECS[i].em));
            if (VECS[i].ev) begin
                chk(tag, "cmd_id", 32'(cmd_id), 32'(VECS[i].ec));
                chk(tag, "cmd_addr", 32'(cmd_addr), 32'(VECS[i].a));
                chk(tag, "cmd_data", 32'(cmd_data), 32'(VECS[i].d));
            end
        end
        busy = 1'b0;
        byte_mode = 1'b0;
        wr(20'h0, 1'b0, 16'h00F0);

        // R3 pulse lasts one cycle, lane bit carried
        wr(20'h00555, 1'b0, 16'h00AA);
        wr(20'h002AA, 1'b0, 16'h0055);
        wr(20'h00555, 1'b0, 16'h00A0);
        wr(20'h0ABCD, 1'b1, 16'hBEEF);
        chk("R3", "cmd_lsb", 32'(cmd_lsb), 32'd1);
        @(negedge clk);
        chk("R3", "pulse width", 32'(cmd_valid), 32'd0);

        // R6 byte-mode query entry from array view
        byte_mode = 1'b1;
        wr(20'h00055, 1'b0, 16'h0098);
        chk("R6", "byte query", 32'(read_mode), 32'd2);
        wr(20'h00000, 1'b0, 16'h00F0);
        chk("R6", "byte query exit", 32'(read_mode), 32'd0);
        byte_mode = 1'b0;

        // R9 bypass flag, F0 ignored inside bypass
        wr(20'h00555, 1'b0, 16'h00AA);
        wr(20'h002AA, 1'b0, 16'h0055);
        wr(20'h00555, 1'b0, 16'h0020);
        chk("R9", "bypass_on set", 32'(bypass_on), 32'd1);
        wr(20'h00000, 1'b0, 16'h00F0);
        chk("R9", "bypass_on kept", 32'(bypass_on), 32'd1);
        wr(20'h00000, 1'b0, 16'h0090);
        wr(20'h00000, 1'b0, 16'h0000);
        chk("R9", "bypass_on cleared", 32'(bypass_on), 32'd0);

        // R10 / R11 suspend flag
        busy = 1'b1;
        wr(20'h00000, 1'b0, 16'h00B0);
        chk("R10", "suspended set", 32'(suspended), 32'd1);
        wr(20'h00000, 1'b0, 16'h00F0);
        chk("R11", "suspended kept after F0", 32'(suspended), 32'd1);
        wr(20'h00000, 1'b0, 16'h0030);
        chk("R11", "suspended cleared", 32'(suspended), 32'd0);
        busy = 1'b0;

        // R1 reset in mid-operation
        wr(20'h00555, 1'b0, 16'h00AA);
        wr(20'h002AA, 1'b0, 16'h0055);
        wr(20'h00555, 1'b0, 16'h0090);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "mode after reset", 32'(read_mode), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule